// File: doc/BRIEF.md
# Atomic Placement Locality Predictor

This block decides, for every atomic memory operation a core issues, whether the operation should run in the local L1 cache or be forwarded to a shared outer cache level. It keeps a small direct-mapped table indexed by the low bits of the cache-block address. Each entry stores a tag, the CPU that touched the block most recently, and a saturating run counter. The counter records how many consecutive atomics on that block came from that CPU. A long enough run from one CPU marks the block as private in practice, and the operation is then kept local. A new block, an evicted block or a change of CPU sends the operation outward.

Requests arrive on a valid/ready stream that carries the block address and the CPU identifier. Each accepted request produces exactly one registered decision on an output valid/ready stream in the following cycle. The output stage holds a single decision. While that decision waits with `dec_ready` low, `req_ready` is low, so no request is accepted and the table is left untouched. The request and decision streams follow the usual rule: a transfer happens on a rising clock edge when valid and ready are both high. A source that has raised valid must keep it high and its payload unchanged until the transfer takes place.

Top module: `apl_predictor`

## Requirements
- R1: After reset `dec_valid` is 0, `req_ready` is 1 and every table entry is empty, so the first access to any block is predicted remote (`dec_local` = 0).
- R2: An accepted request whose block misses the table allocates the entry with that tag and CPU, starts the run count at 1 and is predicted remote.
- R3: An accepted request that hits the table from the recorded CPU increments the run count. The decision is local (`dec_local` = 1) exactly when the new count is greater than LIMIT. With LIMIT = 3, the fourth consecutive access is the first local one.
- R4: An accepted request that hits from a different CPU is predicted remote, records the new CPU and restarts the run count at 1.
- R5: The run count saturates at 2^CNT_W−1 instead of wrapping, so a long run from one CPU stays local indefinitely.
- R6: The table index is the low IDX_W bits of `req_addr` and the tag is the remaining upper bits. A block with the same index and a different tag replaces the entry and is predicted remote, and the evicted block misses when it returns.
- R7: A request accepted on one clock edge shows its decision on `dec_valid`/`dec_local` right after that edge, which is one cycle later.
- R8: While `dec_valid` is 1 and `dec_ready` is 0, `dec_valid` and `dec_local` hold their values, `req_ready` is 0, and a pending request has no effect on the table.
- R9: Blocks at different table indices keep independent run counts, so interleaved accesses do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Cache-block address of the atomic |
| req_cpu | input | CPU_W | Identifier of the requesting CPU |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_local | output | 1 | 1 = run in local L1, 0 = forward to outer level |

## Verification
The hardest situation to reach is a stall that happens while a request is pending. The request stays valid for several cycles behind a held decision, and it must be counted only once when the stall ends. Otherwise a block reaches the local threshold early. The directed stimulus holds `dec_ready` low behind a decision while the next access to the same block waits. It then finishes the run and checks on which access the decision turns local. A long random phase uses a small address space, so index collisions are frequent. It uses a bias toward repeating the previous CPU so that runs reach saturation, and it drops `dec_ready` at random, all compared each cycle against a behavioural model.

// File: rtl/apl_pkg.sv
package apl_pkg;
  // What an accepted request does to its table entry
  typedef enum logic [1:0] {
    EV_ALLOC  = 2'd0,  // miss: new block takes the entry
    EV_SWITCH = 2'd1,  // hit, different CPU: run restarts
    EV_EXTEND = 2'd2   // hit, same CPU: run grows
  } apl_event_e;
endpackage

// File: rtl/apl_table.sv
module apl_table #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  parameter int CPU_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [CPU_W-1:0] rd_cpu,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [CNT_W-1:0] wr_cnt
);
  localparam int DEPTH = 1 << IDX_W;

  logic             ent_valid [DEPTH];
  logic [TAG_W-1:0] ent_tag   [DEPTH];
  logic [CPU_W-1:0] ent_cpu   [DEPTH];
  logic [CNT_W-1:0] ent_cnt   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    wire sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_tag[i]   <= '0;
        ent_cpu[i]   <= '0;
        ent_cnt[i]   <= '0;
      end else if (sel) begin
        ent_valid[i] <= 1'b1;
        ent_tag[i]   <= wr_tag;
        ent_cpu[i]   <= wr_cpu;
        ent_cnt[i]   <= wr_cnt;
      end
    end
  end

  assign rd_valid = ent_valid[rd_idx];
  assign rd_tag   = ent_tag[rd_idx];
  assign rd_cpu   = ent_cpu[rd_idx];
  assign rd_cnt   = ent_cnt[rd_idx];
endmodule

// File: rtl/apl_run_update.sv
module apl_run_update
  import apl_pkg::*;
#(
  parameter int CPU_W = 3,
  parameter int CNT_W = 3,
  parameter int LIMIT = 3
) (
  input  logic             hit,
  input  logic [CPU_W-1:0] rd_cpu,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CPU_W-1:0] req_cpu,
  output logic [CNT_W-1:0] new_cnt,
  output logic             go_local
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  apl_event_e ev;

  always_comb begin
    if (!hit)                  ev = EV_ALLOC;
    else if (rd_cpu != req_cpu) ev = EV_SWITCH;
    else                       ev = EV_EXTEND;
  end

  always_comb begin
    unique case (ev)
      EV_EXTEND: new_cnt = (rd_cnt == CNT_MAX) ? CNT_MAX : rd_cnt + CNT_ONE;
      default:   new_cnt = CNT_ONE;
    endcase
  end

  assign go_local = (ev == EV_EXTEND) && (new_cnt > CNT_W'(LIMIT));
endmodule

// File: rtl/apl_predictor.sv
module apl_predictor #(
  parameter int ADDR_W = 16,
  parameter int CPU_W  = 3,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 3,
  parameter int LIMIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_local
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [CPU_W-1:0] rd_cpu;
  logic [CNT_W-1:0] rd_cnt;
  logic [CNT_W-1:0] new_cnt;
  logic             go_local;
  logic             hit;
  logic             accept;

  assign idx       = req_addr[IDX_W-1:0];
  assign tag       = req_addr[ADDR_W-1:IDX_W];
  assign req_ready = !dec_valid || dec_ready;
  assign accept    = req_valid && req_ready;
  assign hit       = rd_valid && (rd_tag == tag);

  apl_table #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .CPU_W(CPU_W), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_cpu(rd_cpu), .rd_cnt(rd_cnt),
    .wr_en(accept), .wr_idx(idx), .wr_tag(tag),
    .wr_cpu(req_cpu), .wr_cnt(new_cnt)
  );

  apl_run_update #(
    .CPU_W(CPU_W), .CNT_W(CNT_W), .LIMIT(LIMIT)
  ) u_update (
    .hit(hit), .rd_cpu(rd_cpu), .rd_cnt(rd_cnt), .req_cpu(req_cpu),
    .new_cnt(new_cnt), .go_local(go_local)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_local <= 1'b0;
    end else if (accept) begin
      dec_valid <= 1'b1;
      dec_local <= go_local;
    end else if (dec_ready) begin
      dec_valid <= 1'b0;
    end
  end

  // R7
  accept_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dec_valid);

  // R8
  hold_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_local)));

  // R2
  miss_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !dec_local);

  // R4
  switch_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && (rd_cpu != req_cpu)) |=> !dec_local);

  // R5
  sat_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && (rd_cpu == req_cpu) && (rd_cnt == CNT_MAX)) |=> dec_local);
endmodule

// File: tb/apl_predictor_bench.sv
`timescale 1ns/1ps
module apl_predictor_bench;
  localparam int ADDR_W = 16, CPU_W = 3, IDX_W = 4, CNT_W = 3, LIMIT = 3;
  localparam int DEPTH = 16, CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CPU_W-1:0] req_cpu = '0;
  logic dec_ready = 1'b1;
  logic req_ready, dec_valid, dec_local;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  apl_predictor #(.ADDR_W(ADDR_W), .CPU_W(CPU_W), .IDX_W(IDX_W),
                  .CNT_W(CNT_W), .LIMIT(LIMIT)) u_apl_predictor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cpu(req_cpu), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_local(dec_local));

  // Behavioural reference model
  int m_valid [DEPTH];
  int m_tag   [DEPTH];
  int m_cpu   [DEPTH];
  int m_cnt   [DEPTH];
  bit exp_dv = 0, exp_loc = 0, m_last_acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_dv = 0; exp_loc = 0; m_last_acc = 0;
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    end else begin
      bit acc;
      acc = req_valid && (!exp_dv || dec_ready);
      m_last_acc = acc;
      if (acc) begin
        int ix, tg;
        ix = int'(req_addr) % DEPTH;
        tg = int'(req_addr) / DEPTH;
        if (m_valid[ix] == 1 && m_tag[ix] == tg && m_cpu[ix] == int'(req_cpu)) begin
          if (m_cnt[ix] < CMAX) m_cnt[ix]++;
          exp_loc = (m_cnt[ix] > LIMIT);
        end else begin
          m_valid[ix] = 1; m_tag[ix] = tg; m_cpu[ix] = int'(req_cpu);
          m_cnt[ix] = 1; exp_loc = 0;
        end
        exp_dv = 1;
      end else if (dec_ready) exp_dv = 0;
    end
  end

  task automatic chk(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic cmp();
    chk(phase, dec_valid, exp_dv, "dec_valid");
    chk(phase, req_ready, !exp_dv || dec_ready, "req_ready");
    if (exp_dv) chk(phase, dec_local, exp_loc, "dec_local");
  endtask

  task automatic step(bit v, int addr, int cpu, bit rdy);
    @(negedge clk);
    cmp();
    req_valid = v; req_addr = ADDR_W'(addr); req_cpu = CPU_W'(cpu); dec_ready = rdy;
  endtask

  // One request, then look at its decision directly (literal expectation)
  task automatic probe(int addr, int cpu, bit expl, string tag);
    step(1, addr, cpu, 1);
    step(0, 0, 0, 1);
    chk(tag, dec_valid, 1'b1, "dec_valid after accept");
    chk(tag, dec_local, expl, "dec_local literal");
  endtask

  int unsigned rs = 32'h1234_5678;
  function automatic int unsigned nxt();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) step(0, 0, 0, 1);
    chk("R1", dec_valid, 1'b0, "dec_valid in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 1);
    chk("R1", req_ready, 1'b1, "req_ready after reset");
    probe(16'h0107, 1, 0, "R1");

    // R2 + R3: miss then a run from one CPU; fourth access is first local
    phase = "R2"; probe(16'h0015, 1, 0, "R2");
    phase = "R3";
    probe(16'h0015, 1, 0, "R3");
    probe(16'h0015, 1, 0, "R3");
    probe(16'h0015, 1, 1, "R3");

    // R4: CPU change restarts the run
    phase = "R4";
    probe(16'h0015, 2, 0, "R4");
    probe(16'h0015, 2, 0, "R4");
    probe(16'h0015, 2, 0, "R4");
    probe(16'h0015, 2, 1, "R4");

    // R5: long run stays local (wrap would go remote)
    phase = "R5";
    for (int k = 0; k < 10; k++) probe(16'h0015, 2, 1, "R5");

    // R6: same index, different tag evicts
    phase = "R6";
    probe(16'h0025, 2, 0, "R6");
    probe(16'h0015, 2, 0, "R6");

    // R9: independent entries, back to back
    phase = "R9";
    for (int k = 0; k < 4; k++) begin
      step(1, 16'h0001, 3, 1);
      step(1, 16'h0002, 3, 1);
    end
    step(0, 0, 0, 1);
    chk("R9", dec_local, 1'b1, "second block fourth access");
    probe(16'h0001, 3, 1, "R9");

    // R7: decision appears exactly one cycle after acceptance
    phase = "R7";
    step(1, 16'h0203, 5, 1);
    chk("R7", dec_valid, 1'b0, "no decision before edge");
    step(0, 0, 0, 1);
    chk("R7", dec_valid, 1'b1, "decision one cycle later");
    step(0, 0, 0, 1);
    chk("R7", dec_valid, 1'b0, "decision consumed");

    // R8: stall with a pending request to the same block, counted once
    phase = "R8";
    step(1, 16'h0033, 4, 0);
    for (int k = 0; k < 5; k++) begin
      step(1, 16'h0033, 4, 0);
      chk("R8", req_ready, 1'b0, "req_ready during stall");
      chk("R8", dec_local, 1'b0, "held decision");
    end
    step(1, 16'h0033, 4, 1);
    step(0, 0, 0, 1);
    chk("R8", dec_local, 1'b0, "second access after stall remote");
    probe(16'h0033, 4, 0, "R8");
    probe(16'h0033, 4, 1, "R8");

    // Random phase with collisions, repeated CPUs and back-pressure
    phase = "R3";
    begin
      int a, c;
      a = 0; c = 0;
      for (int k = 0; k < 3000; k++) begin
        int unsigned r;
        r = nxt();
        if (!req_valid || m_last_acc) begin
          if (r[3:0] < 3) a = int'(r[11:6]);
          if (r[7:4] < 2) c = int'(r[14:13]);
        end
        if (k == 1000) phase = "R6";
        if (k == 2000) phase = "R8";
        step(r[16:15] != 0, a, c, r[19:18] != 0);
      end
    end
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule